// File: doc/BRIEF.md
# Prescaled PWM Wave Counter

This block is the pulse engine of a four-channel PWM peripheral. A power-of-two prescaler slows the clock into count ticks. A 15-bit wave counter steps on those ticks against a programmable top value. The counter runs either as a sawtooth (count up, then wrap to zero) or as a triangle (count up to top, then back down to zero), and the triangle gives centre-aligned pulses. Each channel compares the counter with its own compare word and drives one output pin. A polarity flag in that word can invert the pin.

A start strobe begins generation from a clean period. A stop strobe never truncates a period: the block finishes the running period, goes idle and pulses a stopped flag. The block pulses a period-end flag at every period boundary. It pulses a load strobe whenever fresh configuration has been captured, so that an external sequencer knows when the next compare values may be presented. Top, mode, prescaler and compare words are held in shadow registers and captured only on a start or at a period boundary. A top-override input, used when a sequencer plays waveform data, replaces the programmed top value at capture time. Dropping the enable input halts everything at once.

Top module: `pwm_wave_core`

## Requirements
- R1: After reset, and while no start has been accepted, all four pins are low and periodEnd, stopped and loadStrobe stay low.
- R2: In sawtooth mode (modeSel=0) the counter runs 0..top and wraps, so periodEnd pulses for one cycle every (top+1)·2^prescSel clock cycles.
- R3: In triangle mode (modeSel=1) the counter runs 0 up to top and back down to 1 before it returns to 0, so periodEnd pulses every 2·top·2^prescSel clock cycles.
- R4: The 3-bit prescSel divides the tick rate by 2^prescSel, from 1 (value 0) to 128 (value 7).
- R5: A top value below 3 is treated as 3. With no prescaling, the shortest sawtooth period is therefore 4 cycles.
- R6: A compare word holds its value in bits [14:0]. In sawtooth mode a pin is high while counter < value, which gives min(value, top+1)·2^prescSel high cycles per period. A value above top holds the pin high for the whole period.
- R7: In triangle mode a compare value c with 1 ≤ c ≤ top gives (2c−1)·2^prescSel high cycles per period, and c=0 gives none.
- R8: Bit 15 of a compare word inverts that channel's pin while the block runs.
- R9: Compare words, top, mode and prescaler are captured only on an accepted start or at a period boundary. loadStrobe pulses one cycle after each capture, which is the cycle periodEnd is seen for a boundary capture. A change made mid-period has no effect until the next boundary.
- R10: While topOvrValid is high, topOvrValue replaces topValue at the next capture.
- R11: A stop request ends generation at the first period boundary at or after the request cycle. In that cycle stopped and periodEnd are both high, loadStrobe is low, and the pins are low from then on.
- R12: With enable low, the pins are low from the next cycle on, no periodEnd or stopped pulse appears, and a later re-enable produces nothing until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low halts and idles at once |
| modeSel | input | 1 | 0 = sawtooth, 1 = triangle (centre-aligned) |
| prescSel | input | 3 | Tick divider exponent (divide by 2^prescSel) |
| topValue | input | 15 | Programmed counter top value |
| topOvrValid | input | 1 | Use topOvrValue in place of topValue at the next capture |
| topOvrValue | input | 15 | Override top value from the waveform sequencer |
| cmpWords | input | 64 | Four compare words; channel i in bits [16i+15:16i]. Bit 15 = polarity, bits [14:0] = value |
| startReq | input | 1 | Start strobe; accepted only when idle and enabled |
| stopReq | input | 1 | Stop strobe; takes effect at the period boundary |
| pwmOut | output | 4 | PWM pins, one per channel |
| periodEnd | output | 1 | One-cycle pulse at every period boundary |
| stopped | output | 1 | One-cycle pulse when a stop completes |
| loadStrobe | output | 1 | One-cycle pulse after shadow values are captured |

## Verification
A stop request and a period boundary can land in the same clock cycle, and the stop must then take effect at that boundary rather than one period later. The bench provokes this case by aligning on a periodEnd pulse and counting down to the last tick of the period. It raises stopReq in exactly that cycle and expects stopped and periodEnd together one cycle later, with no loadStrobe. A second case raises the request right after a boundary. There stopped must arrive a full period later, which shows that a stop never cuts a period short.

// File: rtl/pwm_core_pkg.sv
package pwm_core_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // counter is generating
    logic restart;  // accepted start this cycle: clear counter, capture shadows
    logic load;     // capture shadow registers at this edge
  } ctlStrobe_t;

  typedef enum logic {
    CNT_SAW = 1'b0,
    CNT_TRI = 1'b1
  } cntMode_e;

endpackage

// File: rtl/pwm_wave_chan.sv
module pwm_wave_chan #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          run,
  input  logic [CW:0]   cmpWord,
  input  logic [CW-1:0] cnt,
  output logic          pinOut
);
  logic [CW:0] shWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     shWord <= '0;
    else if (load) shWord <= cmpWord;
  end

  // Active while below compare; top bit inverts
  assign pinOut = run & ((cnt < shWord[CW-1:0]) ^ shWord[CW]);
endmodule

// File: rtl/pwm_wave_datapath.sv
module pwm_wave_datapath
  import pwm_core_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CW      = 15,
  parameter int PSW     = 3,
  parameter int MIN_TOP = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic               modeSel,
  input  logic [PSW-1:0]     prescSel,
  input  logic [CW-1:0]      topValue,
  input  logic               topOvrValid,
  input  logic [CW-1:0]      topOvrValue,
  input  logic [NCH*(CW+1)-1:0] cmpWords,
  output logic               wrapEvt,
  output logic [NCH-1:0]     pwmOut
);
  localparam int PCW = (1 << PSW) - 1;   // prescale counter width
  localparam int WW  = CW + 1;           // compare word width

  logic [PCW-1:0] preCnt;
  logic [PCW-1:0] preMask;
  logic [CW-1:0]  cnt;
  logic           down;
  logic [CW-1:0]  shTop;
  cntMode_e       shMode;
  logic [PSW-1:0] shPresc;
  logic [CW-1:0]  topSel;
  logic [CW-1:0]  topEff;
  logic           tick;
  logic           atEnd;

  always_comb begin
    for (int i = 0; i < PCW; i++) preMask[i] = (PSW'(i) < shPresc);
  end

  assign tick   = ((preCnt & preMask) == preMask);
  assign topSel = topOvrValid ? topOvrValue : topValue;
  assign topEff = (topSel < CW'(MIN_TOP)) ? CW'(MIN_TOP) : topSel;
  assign atEnd  = (shMode == CNT_SAW) ? (cnt == shTop) : (down && cnt == CW'(1));
  assign wrapEvt = ctl.run & tick & atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
      down   <= 1'b0;
    end else if (ctl.restart || !ctl.run) begin
      preCnt <= '0;
      cnt    <= '0;
      down   <= 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (tick) begin
        if (shMode == CNT_SAW) begin
          cnt <= atEnd ? '0 : cnt + 1'b1;
        end else if (!down) begin
          if (cnt == shTop) begin
            down <= 1'b1;
            cnt  <= cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (cnt == CW'(1)) begin
            down <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shTop   <= CW'(MIN_TOP);
      shMode  <= CNT_SAW;
      shPresc <= '0;
    end else if (ctl.load) begin
      shTop   <= topEff;
      shMode  <= cntMode_e'(modeSel);
      shPresc <= prescSel;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_wave_chan #(.CW(CW)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .load   (ctl.load),
      .run    (ctl.run),
      .cmpWord(cmpWords[ch*WW +: WW]),
      .cnt    (cnt),
      .pinOut (pwmOut[ch])
    );
  end
endmodule

// File: rtl/pwm_wave_ctrl.sv
module pwm_wave_ctrl
  import pwm_core_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       wrapEvt,
  output ctlStrobe_t ctl,
  output logic       periodEnd,
  output logic       stopped,
  output logic       loadStrobe
);
  logic runQ;
  logic stopPend;
  logic startFire;
  logic stopHit;

  assign startFire = enable & startReq & ~runQ;
  assign stopHit   = runQ & wrapEvt & (stopPend | stopReq);

  always_comb begin
    ctl.run     = runQ;
    ctl.restart = startFire;
    ctl.load    = startFire | (runQ & enable & wrapEvt & ~stopHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ       <= 1'b0;
      stopPend   <= 1'b0;
      periodEnd  <= 1'b0;
      stopped    <= 1'b0;
      loadStrobe <= 1'b0;
    end else begin
      runQ       <= enable & (startFire | (runQ & ~stopHit));
      stopPend   <= enable & runQ & ~stopHit & (stopPend | stopReq);
      periodEnd  <= enable & runQ & wrapEvt;
      stopped    <= enable & stopHit;
      loadStrobe <= ctl.load;
    end
  end
endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core
  import pwm_core_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CW      = 15,
  parameter int PSW     = 3,
  parameter int MIN_TOP = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  modeSel,
  input  logic [PSW-1:0]        prescSel,
  input  logic [CW-1:0]         topValue,
  input  logic                  topOvrValid,
  input  logic [CW-1:0]         topOvrValue,
  input  logic [NCH*(CW+1)-1:0] cmpWords,
  input  logic                  startReq,
  input  logic                  stopReq,
  output logic [NCH-1:0]        pwmOut,
  output logic                  periodEnd,
  output logic                  stopped,
  output logic                  loadStrobe
);
  ctlStrobe_t ctl;
  logic       wrapEvt;

  pwm_wave_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .wrapEvt   (wrapEvt),
    .ctl       (ctl),
    .periodEnd (periodEnd),
    .stopped   (stopped),
    .loadStrobe(loadStrobe)
  );

  pwm_wave_datapath #(
    .NCH(NCH), .CW(CW), .PSW(PSW), .MIN_TOP(MIN_TOP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .modeSel    (modeSel),
    .prescSel   (prescSel),
    .topValue   (topValue),
    .topOvrValid(topOvrValid),
    .topOvrValue(topOvrValue),
    .cmpWords   (cmpWords),
    .wrapEvt    (wrapEvt),
    .pwmOut     (pwmOut)
  );
endmodule

// File: rtl/pwm_wave_core_chk.sv
module pwm_wave_core_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           enable,
  input logic [NCH-1:0] pwmOut,
  input logic           periodEnd,
  input logic           stopped,
  input logic           loadStrobe
);
  // R11
  stop_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> periodEnd);

  // R11
  stop_idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> (pwmOut == '0));

  // R9
  no_load_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !loadStrobe);

  // R12
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == '0 && !periodEnd && !stopped));

  // R2
  single_period_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> !periodEnd);

  // R11
  single_stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> !stopped);
endmodule

bind pwm_wave_core pwm_wave_core_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .pwmOut    (pwmOut),
  .periodEnd (periodEnd),
  .stopped   (stopped),
  .loadStrobe(loadStrobe)
);

// File: tb/tb_pwm_wave_core.sv
module tb_pwm_wave_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        modeSel = 1'b0;
  logic [2:0]  prescSel = '0;
  logic [14:0] topValue = 15'd9;
  logic        topOvrValid = 1'b0;
  logic [14:0] topOvrValue = '0;
  logic [63:0] cmpWords = '0;
  logic        startReq = 1'b0;
  logic        stopReq = 1'b0;
  logic [3:0]  pwmOut;
  logic        periodEnd;
  logic        stopped;
  logic        loadStrobe;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwm_wave_core dut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .topValue(topValue), .topOvrValid(topOvrValid),
    .topOvrValue(topOvrValue), .cmpWords(cmpWords), .startReq(startReq),
    .stopReq(stopReq), .pwmOut(pwmOut), .periodEnd(periodEnd),
    .stopped(stopped), .loadStrobe(loadStrobe)
  );

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setCmp(int ch, logic [15:0] w);
    cmpWords[ch*16 +: 16] = w;
  endtask

  task automatic waitPe();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!periodEnd && guard < 5000);
  endtask

  task automatic measurePeriod(output int n);
    waitPe();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!periodEnd && n < 5000);
  endtask

  // Starts at a periodEnd sample (counter at 0) and counts high samples over p cycles
  task automatic measureHigh(int ch, int p, output int hi);
    waitPe();
    hi = 0;
    for (int k = 0; k < p; k++) begin
      hi += int'(pwmOut[ch]);
      if (k < p - 1) @(negedge clk);
    end
  endtask

  // Idle the block via enable, then start with the given setup (R9: loadStrobe after start)
  task automatic restart(logic m, logic [2:0] ps, logic [14:0] top);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    modeSel = m;
    prescSel = ps;
    topValue = top;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chkEq("R9", "loadStrobe after start", int'(loadStrobe), 1);
  endtask

  task automatic testReset();
    int seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      seen |= int'(pwmOut) | int'(periodEnd) | int'(stopped) | int'(loadStrobe);
    end
    chkEq("R1", "outputs in reset", seen, 0);
    rstN = 1'b1;
    enable = 1'b1;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      seen |= int'(pwmOut) | int'(periodEnd) | int'(stopped) | int'(loadStrobe);
    end
    chkEq("R1", "outputs idle before start", seen, 0);
  endtask

  task automatic testPeriods();
    int n;
    restart(1'b0, 3'd0, 15'd9);
    measurePeriod(n);
    chkEq("R2", "sawtooth period top=9", n, 10);
    chkEq("R9", "loadStrobe with periodEnd", int'(loadStrobe), 1);
    restart(1'b0, 3'd2, 15'd4);
    measurePeriod(n);
    chkEq("R4", "sawtooth period top=4 div4", n, 20);
    restart(1'b1, 3'd0, 15'd5);
    measurePeriod(n);
    chkEq("R3", "triangle period top=5", n, 10);
    restart(1'b1, 3'd1, 15'd5);
    measurePeriod(n);
    chkEq("R3", "triangle period top=5 div2", n, 20);
    restart(1'b0, 3'd0, 15'd1);
    measurePeriod(n);
    chkEq("R5", "top clamp to 3", n, 4);
  endtask

  task automatic testDuty();
    int hi;
    setCmp(0, 16'h0003);
    setCmp(1, 16'h8003);
    setCmp(2, 16'd20);
    setCmp(3, 16'h0000);
    restart(1'b0, 3'd0, 15'd9);
    measureHigh(0, 10, hi); chkEq("R6", "saw cmp=3 high", hi, 3);
    measureHigh(1, 10, hi); chkEq("R8", "saw inverted cmp=3 high", hi, 7);
    measureHigh(2, 10, hi); chkEq("R6", "saw cmp>top high", hi, 10);
    measureHigh(3, 10, hi); chkEq("R6", "saw cmp=0 high", hi, 0);
    setCmp(0, 16'd2);
    restart(1'b0, 3'd1, 15'd4);
    measureHigh(0, 10, hi); chkEq("R6", "saw cmp=2 div2 high", hi, 4);
    restart(1'b1, 3'd0, 15'd5);
    measureHigh(0, 10, hi); chkEq("R7", "tri cmp=2 high", hi, 3);
    measureHigh(3, 10, hi); chkEq("R7", "tri cmp=0 high", hi, 0);
    measureHigh(1, 10, hi); chkEq("R8", "tri inverted cmp=3 high", hi, 5);
  endtask

  task automatic testShadow();
    int hi;
    setCmp(0, 16'd3);
    restart(1'b0, 3'd0, 15'd9);
    waitPe();
    setCmp(0, 16'd6);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      hi += int'(pwmOut[0]);
      if (k < 9) @(negedge clk);
    end
    chkEq("R9", "mid-period change not applied", hi, 3);
    measureHigh(0, 10, hi);
    chkEq("R9", "change applied after boundary", hi, 6);
  endtask

  task automatic testOverride();
    int n;
    restart(1'b0, 3'd0, 15'd9);
    waitPe();
    topOvrValid = 1'b1;
    topOvrValue = 15'd5;
    measurePeriod(n);
    chkEq("R10", "override top period", n, 6);
    topOvrValid = 1'b0;
    measurePeriod(n);
    chkEq("R10", "period after override removed", n, 10);
  endtask

  task automatic testStop();
    int n = 0;
    int pinsAfter = 0;
    setCmp(2, 16'd20);
    restart(1'b0, 3'd0, 15'd9);
    waitPe();
    stopReq = 1'b1;
    do begin
      @(negedge clk);
      if (n == 0) stopReq = 1'b0;
      n++;
    end while (!stopped && n < 100);
    chkEq("R11", "cycles from request to stopped", n, 10);
    chkEq("R11", "periodEnd with stopped", int'(periodEnd), 1);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      pinsAfter |= int'(pwmOut) | int'(periodEnd);
    end
    chkEq("R11", "idle after stop", pinsAfter, 0);
  endtask

  task automatic testStopCoincide();
    restart(1'b0, 3'd0, 15'd9);
    waitPe();
    repeat (9) @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chkEq("R11", "stopped on coinciding boundary", int'(stopped), 1);
    chkEq("R11", "periodEnd on coinciding boundary", int'(periodEnd), 1);
    chkEq("R11", "no loadStrobe on stop", int'(loadStrobe), 0);
  endtask

  task automatic testDisable();
    int seen = 0;
    setCmp(2, 16'd20);
    restart(1'b0, 3'd0, 15'd9);
    repeat (3) @(negedge clk);
    chkEq("R12", "pin high before disable", int'(pwmOut[2]), 1);
    enable = 1'b0;
    @(negedge clk);
    chkEq("R12", "pins low after disable", int'(pwmOut), 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      seen |= int'(pwmOut) | int'(periodEnd) | int'(stopped);
    end
    enable = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      seen |= int'(pwmOut) | int'(periodEnd) | int'(stopped);
    end
    chkEq("R12", "quiet while disabled and after re-enable", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testPeriods();
    testDuty();
    testShadow();
    testOverride();
    testStop();
    testStopCoincide();
    testDisable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule